// File: doc/BRIEF.md
# 8-bit Compare Timer

This block is an 8-bit counter with two output-compare channels, an overflow flag and two compare-match flags. A 3-bit clock-select input gates counting: a value of zero stops the counter, and any other value advances it once per clock. Dividing the clock down is left to logic outside the block. A 3-bit waveform-mode input chooses one of three counting sequences. Normal mode counts up and wraps. Clear-on-compare mode counts up to channel 0's compare value and then restarts from zero. Dual-slope mode counts up to the maximum and then back down to zero.

Software can load the count and both compare registers at any time. It can also pulse a force strobe per channel. Each channel drives a toggle output that flips on a compare match or on a force strobe. A flag is cleared when software writes a one to its bit or when its interrupt is acknowledged. The flag bit positions are the same for the write-one clear and for the acknowledge: bit 0 is overflow, bit 1 is channel 0 and bit 2 is channel 1.

Top module: `timer8_cmp`

## Requirements
- R1: After the synchronous active-high reset, the count is 0, all flags are 0, both toggle outputs are 0, `at_bottom` is 1 and `at_max` is 0.
- R2: While `clk_sel` is 0 the count holds its value, and a CPU count write still takes effect.
- R3: A count write loads `cnt_wdata` on the next edge and takes priority over counting and clearing in that cycle.
- R4: `wave_mode` 0 selects normal mode, and so does any value from 3 to 7. In normal mode each enabled clock adds 1 to the count, 255 wraps to 0, and the overflow flag sets on that wrap.
- R5: `wave_mode` 2 selects clear-on-compare mode. An enabled clock with the count equal to channel 0's compare value loads 0. A wrap from 255 to 0 sets the overflow flag.
- R6: `wave_mode` 1 selects dual-slope mode. The sequence is 0, 1, …, 255, 254, …, 1, 0, 1, … with a period of 510 enabled clocks. The overflow flag sets on the enabled clock taken at count 0.
- R7: An enabled clock taken while the count equals a channel's compare register sets that channel's flag, visible after that edge. No flag sets while the counter is stopped.
- R8: A force strobe flips that channel's toggle output and never sets its flag. A counted match also flips the toggle output.
- R9: A flag clears on a write-one (`flag_clr_wr` with the flag's bit set in `flag_clr_data`) or on its `irq_ack` bit. Other flags are unaffected. If a set and a clear fall in the same cycle, the set wins.
- R10: `at_max` is 1 exactly when the count is 255, and `at_bottom` is 1 exactly when the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 3 | Clock select; 0 stops counting |
| wave_mode | input | 3 | Counting sequence: 0 normal, 1 dual-slope, 2 clear-on-compare |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write data |
| cmp_wr | input | 2 | Per-channel compare register write strobe |
| cmp_wdata | input | 8 | Compare register write data |
| force_cmp | input | 2 | Per-channel force-compare strobe |
| flag_clr_wr | input | 1 | Write-one flag clear strobe |
| flag_clr_data | input | 3 | Flag clear mask: bit 0 overflow, bits 1..2 channels |
| irq_ack | input | 3 | Interrupt acknowledge, same bit layout |
| count | output | 8 | Current count |
| cmp_flag | output | 2 | Compare-match flags |
| ovf_flag | output | 1 | Overflow flag |
| at_max | output | 1 | Count is 255 |
| at_bottom | output | 1 | Count is 0 |
| wave_out | output | 2 | Per-channel toggle output |

## Verification
A sweep of all 256 compare values loads the counter with the compare value and then takes exactly one enabled clock. This separates a flag that sets on a counted match from one that sets on the compare value alone, and the fixed compare value of the second channel shows that the channels stay independent. Long runs in each counting mode compare every cycle with the arithmetic sequence: count modulo 256, modulo the compare value plus one, and the 510-clock triangle. These runs show the wrap, the clear on compare, and the turn at the top and bottom of the dual-slope sequence. Directed cycles then cover a write during counting, a clear that falls in the same cycle as a set, the acknowledge clear on one bit only, and a force strobe with the count already equal to the compare value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] MODE_NORMAL = 3'd0;
  localparam logic [2:0] MODE_DUAL   = 3'd1;
  localparam logic [2:0] MODE_CTC    = 3'd2;

  localparam int FLG_OVF = 0;

  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/tmr_flag_bit.sv
module tmr_flag_bit (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R9
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> q);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q);
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [2:0]       mode,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             top_hit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_evt,
  output logic             at_max,
  output logic             at_bot
);
  localparam logic [CNT_W-1:0] CMAX  = '1;
  localparam logic [CNT_W-1:0] CZERO = '0;

  dir_e             dir_q, dir_d;
  logic [CNT_W-1:0] cnt_d;
  logic             dual, ctc;

  always_comb begin
    dual     = (mode == MODE_DUAL);
    ctc      = (mode == MODE_CTC);
    cnt_d    = cnt_q;
    dir_d    = dual ? dir_q : DIR_UP;
    wrap_evt = 1'b0;
    if (wr) begin
      cnt_d = wdata;
    end else if (tick) begin
      if (dual) begin
        wrap_evt = (cnt_q == CZERO);
        if (dir_q == DIR_UP) begin
          if (cnt_q == CMAX) begin
            cnt_d = cnt_q - 1'b1;
            dir_d = DIR_DOWN;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == CZERO) begin
            cnt_d = cnt_q + 1'b1;
            dir_d = DIR_UP;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end else begin
        wrap_evt = (cnt_q == CMAX);
        if (ctc && top_hit) cnt_d = CZERO;
        else                cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CZERO;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign at_max = (cnt_q == CMAX);
  assign at_bot = (cnt_q == CZERO);

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr) |=> $stable(cnt_q));
  // R3
  write_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cnt_q == $past(wdata)));
  // R4
  normal_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr && !dual && !ctc) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R5
  ctc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr && ctc && top_hit) |=> (cnt_q == CZERO));
  // R6
  dual_top_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr && dual && cnt_q == CMAX) |=> (cnt_q == CMAX - 1'b1));
  // R6
  dual_bottom_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr && dual && cnt_q == CZERO) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             force_stb,
  input  logic             clr,
  output logic             match,
  output logic             flag,
  output logic             wave
);
  logic [CNT_W-1:0] ocr_q;
  logic             hit;

  always_ff @(posedge clk) begin
    if (rst)     ocr_q <= '0;
    else if (ld) ocr_q <= ld_data;
  end

  assign match = (cnt == ocr_q);
  assign hit   = tick & match;

  tmr_flag_bit u_flag (
    .clk (clk),
    .rst (rst),
    .set (hit),
    .clr (clr),
    .q   (flag)
  );

  always_ff @(posedge clk) begin
    if (rst)                   wave <= 1'b0;
    else if (hit || force_stb) wave <= ~wave;
  end

  // R7
  match_flag_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  // R8
  force_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (force_stb && !hit && !flag) |=> !flag);
  // R8
  force_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    force_stb |=> (wave != $past(wave)));
endmodule

// File: rtl/timer8_cmp.sv
module timer8_cmp
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_CH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       clk_sel,
  input  logic [2:0]       wave_mode,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [N_CH-1:0]  cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [N_CH-1:0]  force_cmp,
  input  logic             flag_clr_wr,
  input  logic [N_CH:0]    flag_clr_data,
  input  logic [N_CH:0]    irq_ack,
  output logic [CNT_W-1:0] count,
  output logic [N_CH-1:0]  cmp_flag,
  output logic             ovf_flag,
  output logic             at_max,
  output logic             at_bottom,
  output logic [N_CH-1:0]  wave_out
);
  localparam int NFLG = N_CH + 1;

  logic            tick;
  logic            wrap_evt;
  logic [NFLG-1:0] clr_vec;
  logic [N_CH-1:0] cmp_match;

  assign tick    = (clk_sel != 3'd0);
  assign clr_vec = ({NFLG{flag_clr_wr}} & flag_clr_data) | irq_ack;

  tmr_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .mode    (wave_mode),
    .wr      (cnt_wr),
    .wdata   (cnt_wdata),
    .top_hit (cmp_match[0]),
    .cnt_q   (count),
    .wrap_evt(wrap_evt),
    .at_max  (at_max),
    .at_bot  (at_bottom)
  );

  tmr_flag_bit u_ovf (
    .clk (clk),
    .rst (rst),
    .set (wrap_evt),
    .clr (clr_vec[FLG_OVF]),
    .q   (ovf_flag)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tmr_cmp_chan #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .cnt      (count),
      .ld       (cmp_wr[i]),
      .ld_data  (cmp_wdata),
      .force_stb(force_cmp[i]),
      .clr      (clr_vec[i+1]),
      .match    (cmp_match[i]),
      .flag     (cmp_flag[i]),
      .wave     (wave_out[i])
    );
  end

  // R10
  max_to_bottom_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && wave_mode == MODE_NORMAL && at_max) |=> (at_bottom && ovf_flag));
  // R7
  any_match_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cmp_match != '0) |=> (cmp_flag != '0));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (count == '0 && !ovf_flag && cmp_flag == '0 && wave_out == '0));
endmodule

// File: tb/timer8_cmp_tb.sv
module timer8_cmp_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] clk_sel, wave_mode;
  logic       cnt_wr;
  logic [7:0] cnt_wdata, cmp_wdata;
  logic [1:0] cmp_wr, force_cmp;
  logic       flag_clr_wr;
  logic [2:0] flag_clr_data, irq_ack;
  logic [7:0] count;
  logic [1:0] cmp_flag, wave_out;
  logic       ovf_flag, at_max, at_bottom;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  timer8_cmp u_dut (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .wave_mode(wave_mode),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .force_cmp(force_cmp), .flag_clr_wr(flag_clr_wr), .flag_clr_data(flag_clr_data),
    .irq_ack(irq_ack), .count(count), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
    .at_max(at_max), .at_bottom(at_bottom), .wave_out(wave_out)
  );

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic done();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    done();
  end

  initial begin
    logic w0;
    rst = 1'b1; clk_sel = 3'd0; wave_mode = 3'd0; cnt_wr = 1'b0; cnt_wdata = '0;
    cmp_wr = '0; cmp_wdata = '0; force_cmp = '0; flag_clr_wr = 1'b0;
    flag_clr_data = '0; irq_ack = '0;
    repeat (3) nx();
    rst = 1'b0;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 flags", {ovf_flag, cmp_flag}, 0);
    chk("R1 wave", wave_out, 0);
    chk("R1 bottom", at_bottom, 1);
    chk("R1 max", at_max, 0);

    // R2 stopped counter holds, write still works
    repeat (5) nx();
    chk("R2 hold", count, 0);
    cnt_wr = 1'b1; cnt_wdata = 8'd77; nx(); cnt_wr = 1'b0;
    chk("R2 write while stopped", count, 77);
    nx(); nx();
    chk("R2 hold after write", count, 77);

    // R3 write beats counting
    clk_sel = 3'd1; cnt_wr = 1'b1; cnt_wdata = 8'd200; nx(); cnt_wr = 1'b0;
    chk("R3 write priority", count, 200);
    nx();
    chk("R4 count after write", count, 201);

    // R4 normal sweep with wrap
    clk_sel = 3'd0; cnt_wr = 1'b1; cnt_wdata = 8'd0;
    flag_clr_wr = 1'b1; flag_clr_data = 3'b111; nx();
    cnt_wr = 1'b0; flag_clr_wr = 1'b0; clk_sel = 3'd1;
    for (int k = 1; k <= 300; k++) begin
      nx();
      chk("R4 normal count", count, k % 256);
      if (k == 255) begin
        chk("R4 no early ovf", ovf_flag, 0);
        chk("R10 at_max", at_max, 1);
      end
      if (k == 256) begin
        chk("R4 ovf on wrap", ovf_flag, 1);
        chk("R10 at_bottom", at_bottom, 1);
      end
    end

    // R4 other mode codes behave as normal, other clock-select codes count
    for (int m = 3; m <= 7; m++) begin
      clk_sel = 3'd0; wave_mode = 3'(m); cnt_wr = 1'b1; cnt_wdata = 8'd100; nx();
      cnt_wr = 1'b0; clk_sel = 3'(m);
      repeat (3) nx();
      chk("R4 spare mode", count, 103);
    end
    wave_mode = 3'd0;

    // R9 set wins over simultaneous write-one clear
    clk_sel = 3'd0; cnt_wr = 1'b1; cnt_wdata = 8'd255;
    flag_clr_wr = 1'b1; flag_clr_data = 3'b111; nx();
    cnt_wr = 1'b0; flag_clr_data = 3'b001; clk_sel = 3'd1; nx();
    flag_clr_wr = 1'b0; clk_sel = 3'd0;
    chk("R9 set wins", ovf_flag, 1);
    chk("R4 wrap to zero", count, 0);

    // R7 sweep of all compare values, channel 1 fixed at 255
    cmp_wr = 2'b10; cmp_wdata = 8'hFF; nx(); cmp_wr = '0;
    w0 = wave_out[0];
    for (int v = 0; v < 256; v++) begin
      cmp_wr = 2'b01; cmp_wdata = 8'(v); cnt_wr = 1'b1; cnt_wdata = 8'(v);
      flag_clr_wr = 1'b1; flag_clr_data = 3'b111; nx();
      cmp_wr = '0; cnt_wr = 1'b0; flag_clr_wr = 1'b0;
      chk("R7 no flag while stopped", cmp_flag[0], 0);
      chk("R2 loaded", count, v);
      clk_sel = 3'd1; nx(); clk_sel = 3'd0;
      chk("R7 flag 0 after match", cmp_flag[0], 1);
      chk("R7 flag 1", cmp_flag[1], (v == 255) ? 1 : 0);
      chk("R4 ovf in sweep", ovf_flag, (v == 255) ? 1 : 0);
      chk("R4 count in sweep", count, (v + 1) % 256);
      chk("R8 toggle on match", wave_out[0], w0 ^ ((v + 1) & 1));
    end

    // R9 acknowledge clears only its own bit (flags: ovf=1, ch0=1, ch1=1)
    irq_ack = 3'b010; nx(); irq_ack = '0;
    chk("R9 ack clears ch0", cmp_flag[0], 0);
    chk("R9 ack leaves ch1", cmp_flag[1], 1);
    chk("R9 ack leaves ovf", ovf_flag, 1);
    flag_clr_wr = 1'b1; flag_clr_data = 3'b100; nx(); flag_clr_wr = 1'b0;
    chk("R9 write-one clears ch1", cmp_flag[1], 0);
    chk("R9 write-one leaves ovf", ovf_flag, 1);

    // R8 force with count equal to compare value, counter stopped
    cmp_wr = 2'b01; cmp_wdata = count; nx(); cmp_wr = '0;
    w0 = wave_out[0];
    force_cmp = 2'b01; nx(); force_cmp = '0;
    chk("R8 force no flag", cmp_flag[0], 0);
    chk("R8 force toggles", wave_out[0], !w0);
    w0 = wave_out[1];
    force_cmp = 2'b10; nx(); force_cmp = '0;
    chk("R8 force ch1 no flag", cmp_flag[1], 0);
    chk("R8 force ch1 toggles", wave_out[1], !w0);

    // R5 clear-on-compare with compare value 9
    wave_mode = 3'd2; clk_sel = 3'd0;
    cmp_wr = 2'b01; cmp_wdata = 8'd9; cnt_wr = 1'b1; cnt_wdata = 8'd0;
    flag_clr_wr = 1'b1; flag_clr_data = 3'b111; nx();
    cmp_wr = '0; cnt_wr = 1'b0; flag_clr_wr = 1'b0; clk_sel = 3'd2;
    for (int k = 1; k <= 40; k++) begin
      nx();
      chk("R5 ctc count", count, k % 10);
    end
    chk("R5 no ovf below top", ovf_flag, 0);
    clk_sel = 3'd0; cnt_wr = 1'b1; cnt_wdata = 8'd250; nx();
    cnt_wr = 1'b0; clk_sel = 3'd1;
    repeat (6) nx();
    clk_sel = 3'd0;
    chk("R5 wrap count", count, 0);
    chk("R5 wrap ovf", ovf_flag, 1);

    // R6 dual-slope triangle
    wave_mode = 3'd1; cnt_wr = 1'b1; cnt_wdata = 8'd0; nx();
    cnt_wr = 1'b0; flag_clr_wr = 1'b1; flag_clr_data = 3'b111; nx();
    flag_clr_wr = 1'b0; clk_sel = 3'd1;
    for (int k = 1; k <= 520; k++) begin
      int p;
      nx();
      p = k % 510;
      chk("R6 dual count", count, (p <= 255) ? p : 510 - p);
      flag_clr_wr = 1'b0;
      if (k == 1) begin
        chk("R6 ovf at start bottom", ovf_flag, 1);
        flag_clr_wr = 1'b1; flag_clr_data = 3'b001;
      end
      if (k == 255) chk("R10 dual at_max", at_max, 1);
      if (k == 256) chk("R10 dual off max", at_max, 0);
      if (k == 510) chk("R6 no ovf before bottom tick", ovf_flag, 0);
      if (k == 511) chk("R6 ovf at bottom", ovf_flag, 1);
    end
    done();
  end
endmodule